// File: doc/BRIEF.md
# Configurable routing and logic cell

This is one tile of a fine-grained reconfigurable array. A single cell evaluates a three-input Boolean function and, in the same cycle, passes raw input signals on to its neighbours. One input is read from a vertical channel track. The other two come from diagonal neighbour links. One output can drive a channel track through a tri-state enable. The other two outputs feed diagonal links. The function result can be used directly or taken from a master/slave storage element. That element can also be fed back into the function in place of the channel input, which is how small state machines are built.

The 26 configuration bits and the storage element form a single serial chain. While `scan_en` is high, the whole chain shifts by one position per clock, entering at `scan_in` and leaving at `scan_out`. This lets software preload the state and read it back later. During the shift every channel driver is forced off, so a half-loaded configuration can never put two drivers on one track. While `scan_en` is low, the configuration holds and the storage element captures the function result on every clock edge.

Top module: `route_logic_cell`

## Requirements
- R1: The function value is bit `{i2,i1,i0}` of an 8-entry truth table. Truth-table entry k sits at configuration bit 18+k.
- R2: Selecting the inputs:
  - i1 is `diag_a_in[cfg[16]]` and i2 is `diag_b_in[cfg[17]]`.
  - i0 is the storage element when the loopback bit cfg[7] is 1.
  - Otherwise i0 is `chan_in[cfg[2:0]]`, and read code 7 gives 0.
- R3: While `scan_en` is low, the storage element takes the function value on each rising clock edge. The result is the stored value when cfg[15] is 1 and the direct function value when cfg[15] is 0.
- R4: Each output has a 2-bit select code: 0 picks i0, 1 picks i1, 2 picks i2 and 3 picks the result.
  - `chan_drv` uses the code in cfg[10:9].
  - `diag_a_out` uses the code in cfg[12:11].
  - `diag_b_out` uses the code in cfg[14:13].
- R5: With `scan_en` low and the drive-enable bit cfg[6] set, `chan_oe` has exactly the bit numbered by cfg[5:3] set. Drive code 7, or cfg[6] clear, enables no track.
- R6: While `scan_en` is high, every bit of `chan_oe` is 0.
- R7: While `scan_en` is low, the configuration bits do not change, so the cell's mapping from inputs to outputs stays fixed across any number of cycles.
- R8: While `scan_en` is high, the 27-bit chain shifts by one position per clock.
  - `scan_in` enters at cfg[0]. Each bit moves toward cfg[25], and cfg[25] moves into the storage element.
  - `scan_out` shows the storage element.
  - To load the chain, shift the state bit first, then cfg[25] down to cfg[0]. Unloading returns the bits in the same order.
  - Bit 8 is a spare bit that only travels along the chain.
- R9: An active-low `rst_n` clears all configuration bits and the storage element. After reset, every output follows `chan_in[0]`, `chan_oe` is 0 and `scan_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift the configuration chain; disables channel drivers |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (storage element) |
| chan_in | input | TRACKS | Vertical channel tracks readable by the cell |
| diag_a_in | input | 2 | Two candidate sources for the first diagonal input |
| diag_b_in | input | 2 | Two candidate sources for the second diagonal input |
| diag_a_out | output | 1 | First diagonal output |
| diag_b_out | output | 1 | Second diagonal output |
| chan_drv | output | 1 | Data the cell offers to the channel |
| chan_oe | output | TRACKS | Per-track tri-state enable for chan_drv |

## Verification
The datapath is tested with random truth tables, input selects and output selects, under random input values. These runs show whether each output picks the right source and whether the table is indexed in the right bit order. Directed configurations cover the cases random stimulus rarely isolates:
- a toggling loopback with a preloaded state, which separates the stored result from the direct result;
- read code 7, which forces a constant channel input;
- drive code 7, which enables no track.

Every reload also unloads the previous chain contents, including the state the cell built up while running. This checks the shift order, and it checks that the configuration held during the run.

// File: rtl/route_logic_cell.sv
module route_logic_cell #(
  parameter int TRACKS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [TRACKS-1:0] chan_in,
  input  logic [1:0]        diag_a_in,
  input  logic [1:0]        diag_b_in,
  output logic              diag_a_out,
  output logic              diag_b_out,
  output logic              chan_drv,
  output logic [TRACKS-1:0] chan_oe
);
  localparam int SW    = $clog2(TRACKS + 1);
  localparam int CH_W  = 2 * SW + 3;
  localparam int RT_LO = CH_W;
  localparam int DG_LO = RT_LO + 7;
  localparam int TT_LO = DG_LO + 2;
  localparam int CFG_W = TT_LO + 8;

  logic [CFG_W-1:0] cfg;
  logic             st;
  logic             chan_rd, i0, i1, i2, f, res;
  logic [7:0]       tt;

  wire [SW-1:0] rd_sel  = cfg[SW-1:0];
  wire [SW-1:0] drv_sel = cfg[2*SW-1:SW];
  wire          drv_en  = cfg[2*SW];
  wire          loop_en = cfg[2*SW+1];

  always_comb begin
    chan_rd = 1'b0;
    for (int t = 0; t < TRACKS; t++) begin
      if (rd_sel == SW'(t)) chan_rd = chan_in[t];
      chan_oe[t] = !scan_en && drv_en && (drv_sel == SW'(t));
    end
  end

  assign i0  = loop_en ? st : chan_rd;
  assign i1  = diag_a_in[cfg[DG_LO]];
  assign i2  = diag_b_in[cfg[DG_LO+1]];
  assign tt  = cfg[TT_LO +: 8];
  assign f   = tt[{i2, i1, i0}];
  assign res = cfg[RT_LO+6] ? st : f;

  function automatic logic pick(input logic [1:0] s, input logic a, b, c, d);
    case (s)
      2'd0:    pick = a;
      2'd1:    pick = b;
      2'd2:    pick = c;
      default: pick = d;
    endcase
  endfunction

  assign chan_drv   = pick(cfg[RT_LO   +: 2], i0, i1, i2, res);
  assign diag_a_out = pick(cfg[RT_LO+2 +: 2], i0, i1, i2, res);
  assign diag_b_out = pick(cfg[RT_LO+4 +: 2], i0, i1, i2, res);
  assign scan_out   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      st  <= 1'b0;
    end else if (scan_en) begin
      cfg <= {cfg[CFG_W-2:0], scan_in};
      st  <= cfg[CFG_W-1];
    end else begin
      st  <= f;
    end
  end
endmodule

module route_logic_cell_chk #(
  parameter int TRACKS = 7,
  parameter int CFG_W  = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic              scan_in,
  input logic [TRACKS-1:0] chan_oe,
  input logic [CFG_W-1:0]  cfg,
  input logic              st,
  input logic              f
);
  p_drv_off_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> chan_oe == '0);

  p_oe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_oe));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(cfg));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> st == $past(f));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (st == $past(cfg[CFG_W-1])) && (cfg[0] == $past(scan_in)));
endmodule

bind route_logic_cell route_logic_cell_chk #(.TRACKS(TRACKS), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
  .chan_oe(chan_oe), .cfg(cfg), .st(st), .f(f)
);

// File: tb/tb_route_logic_cell.sv
module tb_route_logic_cell;
  logic       clk = 0, rst_n = 0, scan_en = 0, scan_in = 0;
  logic       scan_out, diag_a_out, diag_b_out, chan_drv;
  logic [6:0] chan_in = '0, chan_oe;
  logic [1:0] diag_a_in = '0, diag_b_in = '0;

  int checks = 0, errors = 0;

  route_logic_cell dut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic       a, b, d;
    logic [6:0] oe;
  } exp_t;
  exp_t q[$];

  logic [25:0] cur_cfg = '0;
  logic        ms = 0, last_f = 0, running = 0;

  task automatic check(input bit ok, input string what, input logic [6:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input logic [7:0] tt, input logic sa, sb,
      input logic [1:0] o0, o1, o2, input logic rs, input logic [2:0] rd, drv,
      input logic en, lp);
    mk = {tt, sb, sa, rs, o2, o1, o0, 1'b0, lp, en, drv, rd};
  endfunction

  task automatic model(input logic [25:0] c, input logic s, output exp_t e, output logic f);
    logic i0, i1, i2, r;
    logic [3:0] v;
    i0 = c[7] ? s : ((c[2:0] != 3'd7) ? chan_in[c[2:0]] : 1'b0);
    i1 = diag_a_in[c[16]];
    i2 = diag_b_in[c[17]];
    f  = c[18 + {i2, i1, i0}];
    r  = c[15] ? s : f;
    v  = {r, i2, i1, i0};
    e.d  = v[c[10:9]];
    e.a  = v[c[12:11]];
    e.b  = v[c[14:13]];
    e.oe = (c[6] && c[5:3] != 3'd7) ? (7'b1 << c[5:3]) : 7'd0;
  endtask

  // driver: one run-mode cycle, expected item pushed into the scoreboard
  task automatic drive_cycle();
    exp_t e;
    logic f;
    @(negedge clk);
    if (running) ms = last_f;
    running   = 1;
    scan_en   = 0;
    chan_in   = 7'($urandom);
    diag_a_in = 2'($urandom);
    diag_b_in = 2'($urandom);
    model(cur_cfg, ms, e, f);
    q.push_back(e);
    last_f = f;
  endtask

  // monitor: pops and compares away from the clock edge
  initial forever begin
    exp_t e;
    @(negedge clk);
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(diag_a_out == e.a, "R1 R2 R3 R4 diag_a_out", 7'(diag_a_out), 7'(e.a));
      check(diag_b_out == e.b, "R1 R2 R3 R4 diag_b_out", 7'(diag_b_out), 7'(e.b));
      check(chan_drv == e.d, "R4 chan_drv", 7'(chan_drv), 7'(e.d));
      check(chan_oe == e.oe, "R5 chan_oe", chan_oe, e.oe);
    end
  end

  // loads a new chain and unloads the old one (R8), drivers off (R6)
  task automatic scan_swap(input logic nst, input logic [25:0] ncfg);
    logic [26:0] nv, ov;
    if (running) ms = last_f;
    running = 0;
    nv = {nst, ncfg};
    ov = {ms, cur_cfg};
    for (int k = 0; k < 27; k++) begin
      @(negedge clk);
      scan_en = 1;
      scan_in = nv[26-k];
      #5;
      check(scan_out == ov[26-k], "R8 R7 scan_out unload", 7'(scan_out), 7'(ov[26-k]));
      check(chan_oe == 7'd0, "R6 chan_oe during scan", chan_oe, 7'd0);
    end
    cur_cfg = ncfg;
    ms = nst;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    chan_in = 7'h01;
    #15;
    check(scan_out == 0, "R9 scan_out reset", 7'(scan_out), 7'd0);
    check(chan_oe == 0, "R9 chan_oe reset", chan_oe, 7'd0);
    check({diag_a_out, diag_b_out, chan_drv} == 3'b111, "R9 outputs follow chan_in[0]",
          7'({diag_a_out, diag_b_out, chan_drv}), 7'd7);
    chan_in = 7'h7e;
    #1;
    check({diag_a_out, diag_b_out, chan_drv} == 3'b000, "R9 outputs follow chan_in[0] low",
          7'({diag_a_out, diag_b_out, chan_drv}), 7'd0);
    @(negedge clk);
    rst_n = 1;

    // R1 R4: compute and route at once, channel drive on track 4
    scan_swap(1'b0, mk(8'b1110_1000, 1, 0, 2'd3, 2'd1, 2'd2, 0, 3'd2, 3'd4, 1, 0));
    repeat (12) drive_cycle();

    // R3 R2: loopback toggle from preloaded state, stored result
    scan_swap(1'b1, mk(8'h55, 0, 1, 2'd3, 2'd0, 2'd3, 1, 3'd0, 3'd6, 1, 1));
    repeat (8) drive_cycle();

    // R3: direct result vs stored result on same table
    scan_swap(1'b0, mk(8'h96, 1, 1, 2'd3, 2'd3, 2'd0, 0, 3'd5, 3'd0, 1, 1));
    repeat (8) drive_cycle();

    // R2 R5: read code 7 gives 0, drive code 7 enables nothing
    scan_swap(1'b1, mk(8'hf0, 0, 0, 2'd0, 2'd0, 2'd1, 0, 3'd7, 3'd7, 1, 0));
    repeat (8) drive_cycle();

    // R5: enable bit clear
    scan_swap(1'b0, mk(8'h3c, 1, 0, 2'd2, 2'd3, 2'd1, 1, 3'd6, 3'd3, 0, 0));
    repeat (6) drive_cycle();

    // R1 R4 R7: random configurations
    for (int n = 0; n < 30; n++) begin
      scan_swap(1'($urandom), 26'($urandom));
      repeat (10) drive_cycle();
    end
    scan_swap(1'b0, 26'd0);

    @(negedge clk);
    scan_en = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule